// File: doc/BRIEF.md
# Serial Converter I/O Cycle Sequencer

This block is the control sequencer for one serial I/O and conversion cycle of a sampling converter. It watches the serial I/O clock and counts its falling edges. On the fourth accepted falling edge it raises a one-cycle pulse that starts sampling. When the edge count reaches the number selected by the transfer-length code, sampling ends and the conversion starts. A conversion timer then models the fixed conversion time. When the timer expires, a result-latch pulse is issued and the end-of-conversion flag returns high, so a fresh I/O cycle begins.

Chip select is debounced in the system clock domain. Once its debounced level is high, I/O clock edges are ignored, although a conversion already under way still runs to completion. A debounced falling chip select resets the sequencer and aborts any conversion in progress without a latch pulse, so the older result stays in the output register. It then opens an idle window in which I/O clock edges are also ignored.

The debounce time, the idle window and the conversion time are parameters counted in system clock cycles. The default conversion time is 500 cycles, which is 10 µs at 50 MHz.

Top module: `conv_cycle_seq`

## Requirements
- R1: While reset is asserted, `eoc` and `clk_inhibit` are 1, and `samp_start`, `conv_start` and `result_latch` are 0.
- R2: When `cs_n` is driven low and held low, `clk_inhibit` is still 1 at the sample taken DEB_CYC+IDLE_CYC clock edges later, and it is 0 one edge after that.
- R3: A low pulse on `cs_n` that lasts fewer than DEB_CYC clock cycles has no effect, and `clk_inhibit` stays 1.
- R4: Falling edges of `io_clk` that arrive during the idle window after a debounced chip-select fall are not counted.
- R5: `samp_start` pulses in the cycle after the 4th accepted falling edge of `io_clk`, and at no other edge count.
- R6: `eoc` falls and `conv_start` pulses in the cycle after the Nth accepted falling edge, and not before it. N is 8 for `xfer_len`=00, 12 for 01, and 16 for 10 or 11.
- R7: `eoc` stays low for exactly CONV_CYC clock cycles. Falling edges of `io_clk` during that time are ignored. `result_latch` pulses in the same cycle that `eoc` rises, and edge counting then restarts from zero.
- R8: Once the debounced chip select is high, `clk_inhibit` is 1 and `io_clk` edges are ignored. A conversion already running still completes with its latch pulse.
- R9: If a debounced chip-select fall occurs during a conversion, `eoc` rises one cycle after the debounced fall with no `result_latch` pulse, and no latch pulse follows later.
- R10: `samp_start`, `conv_start` and `result_latch` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low, raw |
| io_clk | input | 1 | Serial I/O clock, synchronous to clk |
| xfer_len | input | 2 | Transfer length code: 00=8, 01=12, 1x=16 edges |
| eoc | output | 1 | End of conversion, low while converting |
| samp_start | output | 1 | One-cycle pulse when sampling starts |
| conv_start | output | 1 | One-cycle pulse when sampling ends and conversion starts |
| result_latch | output | 1 | One-cycle pulse when the result is latched |
| clk_inhibit | output | 1 | High while I/O clock edges are ignored |

## Verification
A falling `io_clk` edge is seen at the first `clk` edge where `io_clk` is low after being high. Its registered effects (`samp_start`, `conv_start`, the `eoc` fall) appear one clock later. The bench therefore drives and samples on the falling clock edge directly after that rising edge. `eoc` is then counted low for exactly CONV_CYC samples, and `result_latch` must appear at the first sample where `eoc` is high again. For chip select, the bench counts rising edges from the drive point: the debounced level changes after DEB_CYC edges, the sequencer reacts one edge later, and the idle window adds IDLE_CYC edges. The bench checks `clk_inhibit` and the abort behaviour at those exact counts.

// File: rtl/conv_seq_pkg.sv
package conv_seq_pkg;

    localparam int CNT_W = 5;

    typedef enum logic [1:0] {
        ST_ACQ  = 2'd0,
        ST_CONV = 2'd1,
        ST_IDLE = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] ecnt;
        logic             io_prev;
        logic             eoc;
        logic             samp;
        logic             conv;
        logic             latch;
    } seq_reg_t;

    // transfer length code to number of falling edges closing the sample phase
    function automatic logic [CNT_W-1:0] len_edges(input logic [1:0] code);
        case (code)
            2'b00:   return CNT_W'(8);
            2'b01:   return CNT_W'(12);
            default: return CNT_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/seq_down_timer.sv
module seq_down_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         en,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (en && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);

    AST_TMR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero); // R7
endmodule

// File: rtl/cs_debounce.sv
module cs_debounce #(
    parameter int DEB_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    output logic cs_hi,
    output logic low_evt
);
    localparam int DW = (DEB_CYC < 2) ? 1 : $clog2(DEB_CYC);
    localparam logic [DW-1:0] LAST = DW'(DEB_CYC - 1);

    typedef struct packed {
        logic          db;
        logic [DW-1:0] cnt;
        logic          evt;
    } deb_reg_t;

    deb_reg_t r_d, r_q;

    always_comb begin
        r_d     = r_q;
        r_d.evt = 1'b0;
        if (cs_n != r_q.db) begin
            if (r_q.cnt == LAST) begin
                r_d.db  = cs_n;
                r_d.cnt = '0;
                r_d.evt = !cs_n;
            end else begin
                r_d.cnt = r_q.cnt + 1'b1;
            end
        end else begin
            r_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{db: 1'b1, cnt: '0, evt: 1'b0};
        else        r_q <= r_d;
    end

    assign cs_hi   = r_q.db;
    assign low_evt = r_q.evt;

    AST_DB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n == cs_hi) |=> $stable(cs_hi)); // R3
    AST_EVT_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        low_evt |-> (!cs_hi && $past(cs_hi))); // R2
endmodule

// File: rtl/conv_cycle_seq.sv
module conv_cycle_seq
    import conv_seq_pkg::*;
#(
    parameter int CONV_CYC = 500,
    parameter int DEB_CYC  = 8,
    parameter int IDLE_CYC = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       io_clk,
    input  logic [1:0] xfer_len,
    output logic       eoc,
    output logic       samp_start,
    output logic       conv_start,
    output logic       result_latch,
    output logic       clk_inhibit
);
    localparam int TMAX = (CONV_CYC > IDLE_CYC) ? CONV_CYC : IDLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0]    CONV_LOAD = TW'(CONV_CYC - 1);
    localparam logic [TW-1:0]    IDLE_LOAD = TW'(IDLE_CYC - 1);
    localparam logic [CNT_W-1:0] SAMP_EDGE = CNT_W'(4);

    seq_reg_t r_d, r_q;

    logic cs_hi, low_evt;
    logic conv_zero, idle_zero;
    logic conv_load, conv_en, idle_load, idle_en;
    logic fall, accept;
    logic [CNT_W-1:0] ecnt_nx;

    cs_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n    (cs_n),
        .cs_hi   (cs_hi),
        .low_evt (low_evt)
    );

    seq_down_timer #(.W(TW)) u_conv_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (conv_load),
        .load_val (CONV_LOAD),
        .en       (conv_en),
        .zero     (conv_zero)
    );

    seq_down_timer #(.W(TW)) u_idle_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (idle_load),
        .load_val (IDLE_LOAD),
        .en       (idle_en),
        .zero     (idle_zero)
    );

    always_comb begin
        r_d         = r_q;
        r_d.samp    = 1'b0;
        r_d.conv    = 1'b0;
        r_d.latch   = 1'b0;
        r_d.io_prev = io_clk;
        conv_load   = 1'b0;
        conv_en     = 1'b0;
        idle_load   = 1'b0;
        idle_en     = 1'b0;
        fall        = r_q.io_prev && !io_clk;
        accept      = fall && (r_q.st == ST_ACQ) && !cs_hi && !low_evt;
        ecnt_nx     = r_q.ecnt + 1'b1;

        if (low_evt) begin
            // debounced select fall: reset, abort conversion, open idle window
            r_d.st    = ST_IDLE;
            r_d.ecnt  = '0;
            idle_load = 1'b1;
        end else begin
            case (r_q.st)
                ST_ACQ: begin
                    if (accept) begin
                        r_d.ecnt = ecnt_nx;
                        if (ecnt_nx == SAMP_EDGE) r_d.samp = 1'b1;
                        if (ecnt_nx >= len_edges(xfer_len)) begin
                            r_d.st    = ST_CONV;
                            r_d.conv  = 1'b1;
                            conv_load = 1'b1;
                        end
                    end
                end
                ST_CONV: begin
                    if (conv_zero) begin
                        r_d.st    = ST_ACQ;
                        r_d.ecnt  = '0;
                        r_d.latch = 1'b1;
                    end else begin
                        conv_en = 1'b1;
                    end
                end
                default: begin
                    if (idle_zero) r_d.st = ST_ACQ;
                    else           idle_en = 1'b1;
                end
            endcase
        end
        r_d.eoc = (r_d.st != ST_CONV);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_ACQ, ecnt: '0, io_prev: 1'b0, eoc: 1'b1,
                     samp: 1'b0, conv: 1'b0, latch: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign eoc          = r_q.eoc;
    assign samp_start   = r_q.samp;
    assign conv_start   = r_q.conv;
    assign result_latch = r_q.latch;
    assign clk_inhibit  = cs_hi || low_evt || (r_q.st == ST_IDLE);

    AST_SAMPLE_AT_FOUR: assert property (@(posedge clk) disable iff (!rst_n)
        samp_start |-> (r_q.ecnt == SAMP_EDGE)); // R5
    AST_CONV_AT_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> (!eoc && r_q.ecnt >= len_edges(xfer_len))); // R6
    AST_LATCH_WITH_EOC: assert property (@(posedge clk) disable iff (!rst_n)
        result_latch |-> (eoc && $past(!eoc))); // R7
    AST_EOC_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> (result_latch || clk_inhibit)); // R9
    AST_INHIBIT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_inhibit && !low_evt && r_q.st != ST_CONV) |=> $stable(r_q.ecnt)); // R8
    AST_SAMP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        samp_start |=> !samp_start); // R10
    AST_CONV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start); // R10
    AST_LATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        result_latch |=> !result_latch); // R10
endmodule

// File: tb/conv_cycle_seq_tb_top.sv
module conv_cycle_seq_tb_top;
    localparam int CONV = 20;
    localparam int DEB  = 4;
    localparam int IDLE = 6;

    logic clk = 1'b0;
    logic rst_n, cs_n, io_clk;
    logic [1:0] xfer_len;
    logic eoc, samp_start, conv_start, result_latch, clk_inhibit;
    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    conv_cycle_seq #(.CONV_CYC(CONV), .DEB_CYC(DEB), .IDLE_CYC(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .io_clk(io_clk), .xfer_len(xfer_len),
        .eoc(eoc), .samp_start(samp_start), .conv_start(conv_start),
        .result_latch(result_latch), .clk_inhibit(clk_inhibit)
    );

    function automatic int len_of(input logic [1:0] code);
        return (code == 2'b00) ? 8 : (code == 2'b01) ? 12 : 16;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one io_clk pulse; returns at the sample right after the fall is registered
    task automatic io_pulse(input int hi);
        io_clk = 1'b1;
        step(hi);
        io_clk = 1'b0;
        step(1);
    endtask

    // wait out a running conversion, toggling io_clk early on (must be ignored)
    task automatic conv_wait();
        int cnt = 1;
        while (eoc == 1'b0 && cnt < 1000) begin
            io_clk = (cnt < CONV - 3) ? cnt[0] : 1'b0;
            step(1);
            if (eoc == 1'b0) cnt++;
        end
        check(cnt == CONV, "R7 eoc low cycles", cnt, CONV);
        check(result_latch == 1'b1, "R7 latch at eoc rise", result_latch, 1);
        step(1);
        check(result_latch == 1'b0, "R10 latch single pulse", result_latch, 0);
    endtask

    task automatic run_cycle(input logic [1:0] code, input bit rnd, input bit wait_conv);
        int n = len_of(code);
        xfer_len = code;
        for (int i = 1; i <= n; i++) begin
            io_pulse(rnd ? int'($urandom_range(1, 3)) : 1);
            check(samp_start == (i == 4), "R5 sample pulse", samp_start, int'(i == 4));
            if (i < n) begin
                check(eoc == 1'b1 && conv_start == 1'b0, "R6 no early conversion", eoc, 1);
                if (rnd) step(int'($urandom_range(0, 2)));
            end else begin
                check(eoc == 1'b0 && conv_start == 1'b1, "R6 conversion at length", eoc, 0);
            end
        end
        if (wait_conv) conv_wait();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst_n = 1'b0; cs_n = 1'b1; io_clk = 1'b0; xfer_len = 2'b00;
        step(3);
        check(eoc && clk_inhibit && !samp_start && !conv_start && !result_latch,
              "R1 reset state", {eoc, clk_inhibit, samp_start, conv_start, result_latch}, 5'b11000);
        rst_n = 1'b1;
        step(2);

        // R3: short select glitch
        cs_n = 1'b0;
        step(DEB - 1);
        cs_n = 1'b1;
        for (int k = 0; k < 10; k++) begin
            step(1);
            check(clk_inhibit == 1'b1, "R3 glitch ignored", clk_inhibit, 1);
        end

        // R2 timing with io_clk edges inside the idle window (R4)
        cs_n = 1'b0;
        for (int k = 1; k <= DEB + IDLE + 1; k++) begin
            step(1);
            if (k == DEB + IDLE) check(clk_inhibit == 1'b1, "R2 inhibit before window end", clk_inhibit, 1);
            if (k == DEB + IDLE + 1) check(clk_inhibit == 1'b0, "R2 inhibit released", clk_inhibit, 0);
            io_clk = (k == 6 || k == 8) ? 1'b1 : 1'b0;
        end
        io_clk = 1'b0;
        step(1);

        // R4: edges in window did not count
        xfer_len = 2'b00;
        for (int i = 1; i <= 7; i++) begin
            io_pulse(1);
            check(eoc == 1'b1, "R4 window edges not counted", eoc, 1);
        end
        io_pulse(1);
        check(eoc == 1'b0, "R4 conversion on 8th post-window edge", eoc, 0);
        conv_wait();

        // directed lengths, then random gaps and codes
        run_cycle(2'b01, 1'b0, 1'b1);
        run_cycle(2'b10, 1'b0, 1'b1);
        run_cycle(2'b11, 1'b0, 1'b1);
        for (int it = 0; it < 6; it++) begin
            run_cycle(2'($urandom_range(0, 3)), 1'b1, 1'b1);
        end

        // R8: select rises during conversion; conversion completes, edges ignored
        run_cycle(2'b00, 1'b0, 1'b0);
        cs_n = 1'b1;
        conv_wait();
        check(clk_inhibit == 1'b1, "R8 inhibit while deselected", clk_inhibit, 1);
        for (int i = 0; i < 6; i++) begin
            io_pulse(1);
            check(samp_start == 1'b0 && eoc == 1'b1, "R8 edges ignored", samp_start, 0);
        end
        cs_n = 1'b0;
        step(DEB + IDLE + 1);
        check(clk_inhibit == 1'b0, "R2 reselect releases inhibit", clk_inhibit, 0);

        // R9: abort by debounced select fall during conversion
        run_cycle(2'b00, 1'b0, 1'b0);
        step(2);
        cs_n = 1'b1;
        step(DEB + 2);
        cs_n = 1'b0;
        step(DEB);
        check(eoc == 1'b0, "R9 still converting at debounced fall", eoc, 0);
        step(1);
        check(eoc == 1'b1 && result_latch == 1'b0, "R9 abort eoc high no latch", result_latch, 0);
        for (int k = 0; k < CONV; k++) begin
            step(1);
            check(result_latch == 1'b0 && eoc == 1'b1, "R9 no late latch", result_latch, 0);
        end
        run_cycle(2'b01, 1'b1, 1'b1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule